// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

The block turns an asynchronous serial input into characters. Each character is placed, together with its own error flags, into a receive queue of sixteen entries. The bus side reads the oldest character and a set of line-status flags. A baud generator outside the block supplies a one-cycle tick at sixteen times the bit rate. The frame format comes from static control inputs: the data width (5 to 8 bits), the number of stop bits (one or two), and whether parity is checked and which parity rule applies.

The receiver looks for a start bit and confirms it at mid-bit. It then samples every later bit at its centre, least significant data bit first. It flags parity errors, framing errors, a break on the line and queue overrun. A character's parity, framing and break flags appear in the line status when that character becomes the oldest entry in the queue. A status read clears the flags. One summary flag is the exception: it stays set while any entry that carries an error is still in the queue.

Top module: `uart_rx_status`

## Requirements
- R1: `wl_sel` selects the data width: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8. `data_out` carries the received bits in its low positions, and every bit above the width reads as zero.
- R2: With `par_on` = 1, one parity bit follows the data and `par_mode` sets the rule: 00 = odd (data bits plus parity bit hold an odd number of ones), 01 = even, 10 = parity bit must be 1, 11 = parity bit must be 0. A character that breaks the rule carries a parity error. With `par_on` = 0 no parity bit is expected and no parity error is raised.
- R3: `stop2` = 0 expects one stop bit and `stop2` = 1 expects two. A character with any sampled stop bit at 0 carries a framing error, unless it is a break (R7).
- R4: A falling edge starts a character only if the input is still low at the start bit's centre, the 8th oversampling tick. A shorter low pulse stores nothing. The block samples data bits at their centres, least significant bit first.
- R5: The queue holds 16 characters. `data_ready` is 1 exactly when the queue is not empty. `data_out` shows the oldest entry. A one-cycle `rd_data` pulse removes that entry, and has no effect on an empty queue.
- R6: A character that completes while the queue is full is discarded, the queue contents stay unchanged, and `overrun` is set.
- R7: A character whose every sampled bit is 0, stop bits included, is stored as data 0 with the break flag set and no parity or framing error. After a break the receiver ignores the line until the input has stayed high for one full character time, which is 16 × (start + data + parity + stop bits) ticks.
- R8: `parity_err`, `frame_err` and `break_det` are set when a character carrying that error becomes the oldest entry. A one-cycle `rd_status` pulse clears all three and `overrun`. A flag that is set in the same cycle as the read stays set.
- R9: `fifo_err` is set when a character carrying any error (parity, framing or break) is stored. A status read clears it only if no errored entry remains in the queue.
- R10: A `fifo_clr` pulse empties the queue, so `data_ready` is 0 in the following cycle.
- R11: After reset, `data_ready`, `overrun`, `parity_err`, `frame_err`, `break_det` and `fifo_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial input line, idle high |
| wl_sel | input | 2 | Data width code |
| stop2 | input | 1 | Two stop bits when 1 |
| par_on | input | 1 | Parity bit present and checked |
| par_mode | input | 2 | Parity rule code |
| fifo_clr | input | 1 | Empty the receive queue |
| rd_data | input | 1 | Remove the oldest character |
| rd_status | input | 1 | Status read; clears the line flags |
| data_out | output | 8 | Oldest character, zero-filled above the data width |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | A character was lost to a full queue |
| parity_err | output | 1 | Parity error seen at the queue head |
| frame_err | output | 1 | Framing error seen at the queue head |
| break_det | output | 1 | Break seen at the queue head |
| fifo_err | output | 1 | An errored entry was stored and has not been cleared |

## Verification
The hardest state to reach is the recovery window after a break. The stimulus drives a long low line, then lets the line go high for only a few bit times and sends a full character. That character must not appear in the queue. After a long idle period a further character must arrive intact. Overrun needs seventeen back-to-back characters with no read in between. A later drain then shows the original sixteen, in order, and nothing after them. The persistence of the summary flag is checked by reading status while an errored entry is still queued, and again after that entry has been removed.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK,
        ST_WAITHI
    } rx_state_t;

endpackage

// File: rtl/uart_rxs_deser.sv
module uart_rxs_deser
    import uart_rxs_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] wl,
    input  logic       two_stop,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    output logic       push,
    output rx_entry_t  entry
);
    localparam int TW = $clog2(OSR);
    localparam int HW = $clog2(OSR * 12 + 1);
    localparam logic [TW-1:0] T_MID = TW'(OSR / 2 - 2);
    localparam logic [TW-1:0] T_END = TW'(OSR - 1);

    typedef struct packed {
        rx_state_t     st;
        logic [TW-1:0] tcnt;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic          pacc;
        logic          pe;
        logic          fe;
        logic          allz;
        logic [HW-1:0] hcnt;
        logic          s1;
        logic          s2;
    } dstate_t;

    dstate_t q, d;
    logic       rx_s;
    logic [3:0] nbits;
    logic [3:0] frame_bits;
    logic [HW-1:0] cticks;
    logic [2:0] last_bit;

    assign rx_s       = q.s2;
    assign nbits      = {2'b00, wl} + 4'd5;
    assign frame_bits = 4'd2 + nbits + {3'b000, par_en} + {3'b000, two_stop};
    assign cticks     = HW'(OSR) * HW'(frame_bits);
    assign last_bit   = {1'b0, wl} + 3'd4;

    always_comb begin
        logic allz_f;
        logic fe_f;
        d      = q;
        d.s1   = rx;
        d.s2   = q.s1;
        push   = 1'b0;
        entry  = '0;
        allz_f = 1'b0;
        fe_f   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (tick && !rx_s) begin
                    d.st   = ST_START;
                    d.tcnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.tcnt == T_MID) begin
                        if (rx_s) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st   = ST_DATA;
                            d.tcnt = '0;
                            d.bitn = '0;
                            d.sh   = '0;
                            d.pacc = 1'b0;
                            d.pe   = 1'b0;
                            d.fe   = 1'b0;
                            d.allz = 1'b1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.tcnt == T_END) begin
                        d.tcnt = '0;
                        d.sh   = {rx_s, q.sh[7:1]};
                        d.pacc = q.pacc ^ rx_s;
                        d.allz = q.allz & ~rx_s;
                        if (q.bitn == last_bit) begin
                            d.bitn = '0;
                            d.st   = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (q.tcnt == T_END) begin
                        d.tcnt = '0;
                        d.allz = q.allz & ~rx_s;
                        d.st   = ST_STOP;
                        case (par_sel)
                            2'b00:   d.pe = ~(q.pacc ^ rx_s);
                            2'b01:   d.pe = q.pacc ^ rx_s;
                            2'b10:   d.pe = ~rx_s;
                            default: d.pe = rx_s;
                        endcase
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.tcnt == T_END) begin
                        d.tcnt = '0;
                        allz_f = q.allz & ~rx_s;
                        fe_f   = q.fe | ~rx_s;
                        d.allz = allz_f;
                        d.fe   = fe_f;
                        if (q.bitn[0] == two_stop) begin
                            push = 1'b1;
                            d.bitn = '0;
                            if (allz_f) begin
                                entry.brk = 1'b1;
                                d.st      = ST_BRK;
                                d.hcnt    = '0;
                            end else begin
                                entry.fe   = fe_f;
                                entry.pe   = q.pe;
                                entry.data = q.sh >> (2'd3 - wl);
                                d.st       = ST_WAITHI;
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            ST_BRK: begin
                if (tick) begin
                    if (!rx_s) begin
                        d.hcnt = '0;
                    end else if (q.hcnt == cticks - 1'b1) begin
                        d.hcnt = '0;
                        d.st   = ST_IDLE;
                    end else begin
                        d.hcnt = q.hcnt + 1'b1;
                    end
                end
            end
            ST_WAITHI: begin
                if (rx_s) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, tcnt: '0, bitn: '0, sh: '0, pacc: 1'b0,
                   pe: 1'b0, fe: 1'b0, allz: 1'b0, hcnt: '0, s1: 1'b1, s2: 1'b1};
        end else begin
            q <= d;
        end
    end

    // R1: a stored character never has bits set above the selected width
    assert_zero_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((entry.data >> nbits) == 8'd0));

    // R7: a low line keeps the receiver in break recovery
    assert_break_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BRK && tick && !rx_s) |=> (q.st == ST_BRK && q.hcnt == '0));

endmodule

// File: rtl/uart_rxs_fifo.sv
module uart_rxs_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fstate_t;

    fstate_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (q.cnt == FULLC);
    assign empty = (q.cnt == '0);
    assign count = q.cnt;
    assign rdata = mem[q.rp];

    always_comb begin
        d       = q;
        do_pop  = pop && !empty && !clr;
        do_push = push && (!full || do_pop) && !clr;
        if (clr) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) d.wp = (q.wp == LAST) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    // R6: a push into a full queue without a pop changes nothing
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == FULLC && $stable(rdata)));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rxs_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic [1:0] wl_sel,
    input  logic       stop2,
    input  logic       par_on,
    input  logic [1:0] par_mode,
    input  logic       fifo_clr,
    input  logic       rd_data,
    input  logic       rd_status,
    output logic [7:0] data_out,
    output logic       data_ready,
    output logic       overrun,
    output logic       parity_err,
    output logic       frame_err,
    output logic       break_det,
    output logic       fifo_err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = $bits(rx_entry_t);

    typedef struct packed {
        logic          ovr;
        logic          pe;
        logic          fe;
        logic          brk;
        logic          ferr;
        logic          seen;
        logic [CW-1:0] ecnt;
    } tstate_t;

    tstate_t q, d;

    logic          push;
    rx_entry_t     new_ent;
    rx_entry_t     head;
    logic [EW-1:0] head_raw;
    logic [CW-1:0] count;
    logic          full, empty;
    logic          pop_ok, push_acc, ovr_set, latch, push_err, pop_err;

    uart_rxs_deser #(.OSR(OSR)) i_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx       (rx_in),
        .wl       (wl_sel),
        .two_stop (stop2),
        .par_en   (par_on),
        .par_sel  (par_mode),
        .push     (push),
        .entry    (new_ent)
    );

    uart_rxs_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (push),
        .wdata (new_ent),
        .pop   (pop_ok),
        .rdata (head_raw),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    assign head = rx_entry_t'(head_raw);

    always_comb begin
        d        = q;
        pop_ok   = rd_data && !empty;
        push_acc = push && (!full || pop_ok) && !fifo_clr;
        ovr_set  = push && full && !pop_ok;
        latch    = !empty && !q.seen && !fifo_clr;
        push_err = push_acc && (new_ent.pe || new_ent.fe || new_ent.brk);
        pop_err  = pop_ok && !fifo_clr && (head.pe || head.fe || head.brk);

        if (fifo_clr || pop_ok) d.seen = 1'b0;
        else if (latch)         d.seen = 1'b1;

        d.pe  = (q.pe  && !rd_status) || (latch && head.pe);
        d.fe  = (q.fe  && !rd_status) || (latch && head.fe);
        d.brk = (q.brk && !rd_status) || (latch && head.brk);
        d.ovr = (q.ovr && !rd_status) || ovr_set;

        if (fifo_clr) d.ecnt = '0;
        else          d.ecnt = q.ecnt + CW'(push_err) - CW'(pop_err);

        d.ferr = push_err || (q.ferr && !(rd_status && d.ecnt == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_out   = head.data;
    assign data_ready = !empty;
    assign overrun    = q.ovr;
    assign parity_err = q.pe;
    assign frame_err  = q.fe;
    assign break_det  = q.brk;
    assign fifo_err   = q.ferr;

    // R5: taking the last entry leaves the queue empty
    assert_last_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(1) && pop_ok && !push) |=> !data_ready);

    // R6: a lost character raises the overrun flag
    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> overrun);

    // R8: a status read with no new event leaves every line flag clear
    assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !latch && !ovr_set) |=> !(parity_err || frame_err || break_det || overrun));

    // R9: the summary flag survives while errored entries remain
    assert_ferr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_err && d.ecnt != '0) |=> fifo_err);

    // R10: a clear leaves nothing to read
    assert_clear_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !data_ready);

endmodule

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
    localparam int BITC = 64;   // 16 ticks per bit, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       rx_in = 1'b1;
    logic [1:0] wl_sel = 2'b11;
    logic       stop2 = 1'b0;
    logic       par_on = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       fifo_clr = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] data_out;
    logic       data_ready, overrun, parity_err, frame_err, break_det, fifo_err;
    logic [1:0] tdiv;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tdiv <= 2'd0;
        else        tdiv <= tdiv + 2'd1;
    end
    assign tick16 = (tdiv == 2'd3);

    uart_rx_status i_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .wl_sel(wl_sel), .stop2(stop2), .par_on(par_on), .par_mode(par_mode),
        .fifo_clr(fifo_clr), .rd_data(rd_data), .rd_status(rd_status),
        .data_out(data_out), .data_ready(data_ready), .overrun(overrun),
        .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det),
        .fifo_err(fifo_err)
    );

    // fields: wl[15:14] par_on[13] par_mode[12:11] stop2[10] bad_par[9] bad_stop[8] data[7:0]
    localparam logic [15:0] VEC [8] = '{
        16'hC0A5, 16'h00FF, 16'h602A, 16'hAA13,
        16'hF43C, 16'hFA81, 16'hC17E, 16'h8555
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        rx_in = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] dat, input logic bad_par, input logic bad_stop);
        int nb;
        logic x, p;
        nb = int'(wl_sel) + 5;
        x = 1'b0;
        for (int i = 0; i < nb; i++) x = x ^ dat[i];
        case (par_mode)
            2'b00:   p = ~x;
            2'b01:   p = x;
            2'b10:   p = 1'b1;
            default: p = 1'b0;
        endcase
        if (bad_par) p = ~p;
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(dat[i]);
        if (par_on) bit_out(p);
        if (stop2) bit_out(1'b1);
        bit_out(~bad_stop);
        rx_in = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic pulse_status();
        rd_status = 1'b1; @(negedge clk);
        rd_status = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_pop();
        rd_data = 1'b1; @(negedge clk);
        rd_data = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 01 expected 00");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] mask, expd;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 data_ready", {7'b0, data_ready}, 8'h00);
        chk("R11 flags", {3'b0, overrun, parity_err, frame_err, break_det, fifo_err}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 after release", {2'b0, data_ready, overrun, parity_err, frame_err, break_det, fifo_err}, 8'h00);

        // vector walk: widths, parity rules, stop counts
        foreach (VEC[k]) begin
            wl_sel   = VEC[k][15:14];
            par_on   = VEC[k][13];
            par_mode = VEC[k][12:11];
            stop2    = VEC[k][10];
            repeat (BITC) @(negedge clk);
            send(VEC[k][7:0], VEC[k][9], VEC[k][8]);
            mask = 8'((16'd1 << (int'(VEC[k][15:14]) + 5)) - 16'd1);
            expd = VEC[k][7:0] & mask;
            chk("R5 ready after char", {7'b0, data_ready}, 8'h01);
            chk("R1/R4 data value", data_out, expd);
            chk("R2 parity flag", {7'b0, parity_err}, {7'b0, VEC[k][13] & VEC[k][9]});
            chk("R3 framing flag", {7'b0, frame_err}, {7'b0, VEC[k][8]});
            chk("R7 no break on normal char", {7'b0, break_det}, 8'h00);
            pulse_status();
            chk("R8 flags cleared by read", {5'b0, parity_err, frame_err, break_det}, 8'h00);
            pulse_pop();
            chk("R5 empty after pop", {7'b0, data_ready}, 8'h00);
            pulse_status();
            chk("R9 summary cleared when queue empty", {7'b0, fifo_err}, 8'h00);
        end

        // R4 glitch rejection
        wl_sel = 2'b11; par_on = 1'b0; stop2 = 1'b0; par_mode = 2'b00;
        rx_in = 1'b0;
        repeat (8) @(negedge clk);
        rx_in = 1'b1;
        repeat (20 * BITC) @(negedge clk);
        chk("R4 short low pulse ignored", {7'b0, data_ready}, 8'h00);

        // R9 summary flag persistence
        par_on = 1'b1; par_mode = 2'b00;
        send(8'h11, 1'b1, 1'b0);
        send(8'h22, 1'b0, 1'b0);
        chk("R9 summary set", {7'b0, fifo_err}, 8'h01);
        pulse_status();
        chk("R9 summary kept with errored entry queued", {7'b0, fifo_err}, 8'h01);
        chk("R8 parity cleared", {7'b0, parity_err}, 8'h00);
        pulse_pop();
        chk("R5 second char at head", data_out, 8'h22);
        chk("R8 clean head raises nothing", {7'b0, parity_err}, 8'h00);
        pulse_status();
        chk("R9 summary cleared after errored entry gone", {7'b0, fifo_err}, 8'h00);
        pulse_pop();

        // R6 overrun and R5 ordering
        par_on = 1'b0;
        for (int i = 0; i < 17; i++) send(8'(i * 3 + 1), 1'b0, 1'b0);
        chk("R6 overrun set", {7'b0, overrun}, 8'h01);
        for (int i = 0; i < 16; i++) begin
            chk("R5 oldest first", data_out, 8'(i * 3 + 1));
            pulse_pop();
        end
        chk("R6 seventeenth char discarded", {7'b0, data_ready}, 8'h00);
        pulse_status();
        chk("R8 overrun cleared", {7'b0, overrun}, 8'h00);

        // R7 break and recovery
        rx_in = 1'b0;
        repeat (11 * BITC) @(negedge clk);
        rx_in = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        chk("R7 break stored", {7'b0, data_ready}, 8'h01);
        chk("R7 break data zero", data_out, 8'h00);
        chk("R7 break flag", {7'b0, break_det}, 8'h01);
        chk("R7 no parity or framing on break", {6'b0, parity_err, frame_err}, 8'h00);
        chk("R9 break counts as error", {7'b0, fifo_err}, 8'h01);
        send(8'h55, 1'b0, 1'b0);
        pulse_pop();
        chk("R7 char during recovery ignored", {7'b0, data_ready}, 8'h00);
        pulse_status();
        chk("R8 break cleared", {7'b0, break_det}, 8'h00);
        repeat (12 * BITC) @(negedge clk);
        send(8'hA5, 1'b0, 1'b0);
        chk("R7 receiver back after recovery", data_out, 8'hA5);
        pulse_pop();

        // R10 queue clear
        send(8'h3C, 1'b0, 1'b0);
        send(8'hC3, 1'b0, 1'b0);
        chk("R10 queue filled", {7'b0, data_ready}, 8'h01);
        fifo_clr = 1'b1; @(negedge clk);
        fifo_clr = 1'b0; @(negedge clk);
        chk("R10 queue empty after clear", {7'b0, data_ready}, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule